// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches a running BCD calendar (hundredths, seconds, minutes, hours, date, month and weekday) supplied by a separate timekeeping counter. It compares that calendar against a set of programmed alarm values. A three-bit repeat code picks which calendar fields must agree: a yearly alarm compares everything except the weekday, and a per-second alarm compares only the hundredths. When every selected field agrees in a cycle where the hundredths strobe is high, a sticky alarm flag is set. An active-low interrupt can follow the flag, or it can give a pulse of fixed width.

Software reaches the block through a single-cycle write port and a combinational read port. Registers 0 to 6 hold the alarm fields. Register 7 holds the repeat code, the interrupt output mode and the interrupt enable. Register 8 holds the status, with the alarm flag at bit 2. A hundredths alarm value that has 0xF in a nibble treats that digit as a wildcard. This gives tenth-second alarms (upper nibble 0xF) and hundredth-second alarms (value 0xFF) under repeat code 7.

Top module: `alarm_match`

## Requirements
- R1: After reset, every register reads 0, `alarm_flag` is 0 and `irq_n` is 1. Registers are laid out as follows:
  - Addresses 0..6 hold the alarm hundredths, seconds, minutes, hour, date, month and weekday, and read back as written.
  - Address 7 is control: bits [2:0] repeat code, [4:3] interrupt mode, [7] interrupt enable. Bits 6:5 read as 0.
  - Address 8 is status: bit 2 is the alarm flag and all other bits read 0.
- R2: A match is evaluated only in a cycle where `tick` is 1. The flag becomes 1 at the clock edge that samples that tick. Matching fields with `tick` at 0 never set the flag.
- R3: Repeat code 0 never sets the flag, even if every field matches.
- R4: The repeat code selects the compared fields:
  - 1 compares month, date, hour, minute, second and hundredths.
  - 2 compares date, hour, minute, second and hundredths.
  - 3 compares weekday, hour, minute, second and hundredths.
  - 4 compares hour, minute, second and hundredths.
  - 5 compares minute, second and hundredths.
  - 6 compares second and hundredths.
  - 7 compares hundredths only.
  - Fields that are not selected are ignored.
- R5: Only the following bits take part in the compare:
  - Seconds and minutes: bits 6:0.
  - Hour: bits 5:0. This covers both 24-hour BCD and 12-hour BCD, where bit 5 is the PM flag.
  - Date: bits 5:0.
  - Month: bits 4:0.
  - Weekday: bits 2:0.
  - Higher bits are ignored.
- R6: A hundredths alarm nibble equal to 0xF matches any current digit. For example, 0xF5 matches x5, and 0xFF matches every tick.
- R7: The flag is sticky. A write to address 8 with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R8: `irq_n` stays 1 while the interrupt enable is 0, whatever the flag.
- R9: In mode 0 (level) with the enable set, `irq_n` is 0 exactly while the flag is 1.
- R10: Modes 1, 2 and 3 give a low pulse on `irq_n` that starts at the match edge. The pulse lasts 1, 128 or 2048 `ref_8k` enables respectively and does not depend on the flag. It is started only when the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe, one per hundredths step of the calendar |
| ref_8k | input | 1 | 8192 Hz enable used to time interrupt pulses |
| now_hund | input | 8 | Current hundredths, BCD |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hour, BCD, 12- or 24-hour form |
| now_date | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| now_wday | input | 8 | Current weekday |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Alarm interrupt, active low |

## Verification
The hardest case to reach is the collision of a matching tick with a software write that clears the flag in the same cycle. The stimulus produces it by raising `tick` together with a status write of 0 on one negative edge, so that both land on the same rising edge. A second case is the longest pulse width, 2048 reference enables. The bench holds `ref_8k` high so that width becomes an exact cycle count, and it counts low cycles at every falling edge. The don't-care behaviour of each repeat code is shown by changing one field at a time away from the programmed alarm.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int PULSE_SHORT = 1,
  parameter int PULSE_MID   = 128,
  parameter int PULSE_LONG  = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ref_8k,
  input  logic [DW-1:0] now_hund,
  input  logic [DW-1:0] now_sec,
  input  logic [DW-1:0] now_min,
  input  logic [DW-1:0] now_hour,
  input  logic [DW-1:0] now_date,
  input  logic [DW-1:0] now_month,
  input  logic [DW-1:0] now_wday,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          alarm_flag,
  output logic          irq_n
);
  localparam int NFLD = 7;
  localparam logic [AW-1:0] A_CTRL = AW'(NFLD);
  localparam logic [AW-1:0] A_STAT = AW'(NFLD + 1);
  localparam int FLAG_BIT = 2;
  localparam int CW = $clog2(PULSE_LONG + 1);

  localparam logic [DW-1:0] M_SEC  = DW'(8'h7F);
  localparam logic [DW-1:0] M_HOUR = DW'(8'h3F);
  localparam logic [DW-1:0] M_DATE = DW'(8'h3F);
  localparam logic [DW-1:0] M_MON  = DW'(8'h1F);
  localparam logic [DW-1:0] M_WDAY = DW'(8'h07);

  logic [DW-1:0] al_q [NFLD];
  logic [2:0]    rpt_q;
  logic [1:0]    im_q;
  logic          aie_q;
  logic          flag_q;
  logic [CW-1:0] pcnt_q;

  function automatic logic fld_eq(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic [DW-1:0] m);
    return ((a ^ b) & m) == '0;
  endfunction

  wire hund_hi = (al_q[0][7:4] == 4'hF) || (al_q[0][7:4] == now_hund[7:4]);
  wire hund_lo = (al_q[0][3:0] == 4'hF) || (al_q[0][3:0] == now_hund[3:0]);
  wire sec_ok  = fld_eq(al_q[1], now_sec,   M_SEC);
  wire min_ok  = fld_eq(al_q[2], now_min,   M_SEC);
  wire hour_ok = fld_eq(al_q[3], now_hour,  M_HOUR);
  wire date_ok = fld_eq(al_q[4], now_date,  M_DATE);
  wire mon_ok  = fld_eq(al_q[5], now_month, M_MON);
  wire wday_ok = fld_eq(al_q[6], now_wday,  M_WDAY);

  wire use_sec  = rpt_q <= 3'd6;
  wire use_min  = rpt_q <= 3'd5;
  wire use_hour = rpt_q <= 3'd4;
  wire use_date = (rpt_q == 3'd1) || (rpt_q == 3'd2);
  wire use_mon  = rpt_q == 3'd1;
  wire use_wday = rpt_q == 3'd3;

  wire hit = tick && (rpt_q != 3'd0) && hund_hi && hund_lo
           && (!use_sec  || sec_ok)  && (!use_min  || min_ok)
           && (!use_hour || hour_ok) && (!use_date || date_ok)
           && (!use_mon  || mon_ok)  && (!use_wday || wday_ok);

  wire wr_ctrl = reg_we && (reg_addr == A_CTRL);
  wire wr_clr  = reg_we && (reg_addr == A_STAT) && !reg_wdata[FLAG_BIT];

  logic [CW-1:0] pwidth;
  always_comb begin
    case (im_q)
      2'd1:    pwidth = CW'(PULSE_SHORT);
      2'd2:    pwidth = CW'(PULSE_MID);
      default: pwidth = CW'(PULSE_LONG);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFLD; i++) al_q[i] <= '0;
      rpt_q <= '0;
      im_q  <= '0;
      aie_q <= 1'b0;
    end else if (reg_we) begin
      for (int i = 0; i < NFLD; i++)
        if (reg_addr == AW'(i)) al_q[i] <= reg_wdata;
      if (wr_ctrl) begin
        rpt_q <= reg_wdata[2:0];
        im_q  <= reg_wdata[4:3];
        aie_q <= reg_wdata[7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (wr_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt_q <= '0;
    else if (hit && aie_q && (im_q != 2'd0))
      pcnt_q <= pwidth;
    else if (ref_8k && (pcnt_q != '0))
      pcnt_q <= pcnt_q - 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < A_CTRL)       reg_rdata = al_q[reg_addr[2:0]];
    else if (reg_addr == A_CTRL) reg_rdata = {aie_q, 2'b00, im_q, rpt_q};
    else if (reg_addr == A_STAT) reg_rdata[FLAG_BIT] = flag_q;
  end

  assign alarm_flag = flag_q;
  assign irq_n = !(aie_q && ((im_q == 2'd0) ? flag_q : (pcnt_q != '0)));
endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       reg_we,
  input logic [3:0] reg_addr,
  input logic       wdata_flag,
  input logic       alarm_flag,
  input logic       irq_n,
  input logic [2:0] rpt,
  input logic [1:0] im,
  input logic       aie
);
  a_r2_flag_only_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick));

  a_r3_disabled_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rpt == 3'd0 && !alarm_flag) |=> !alarm_flag);

  a_r7_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd8 && !wdata_flag && !tick) |=> !alarm_flag);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> aie);

  a_r9_level_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (aie && im == 2'd0) |-> (irq_n == !alarm_flag));

  a_r10_pulse_starts_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (im != 2'd0 && $fell(irq_n) && $stable(aie) && $stable(im)) |-> $past(tick));
endmodule

bind alarm_match alarm_match_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
  .wdata_flag(reg_wdata[2]), .alarm_flag(alarm_flag), .irq_n(irq_n),
  .rpt(rpt_q), .im(im_q), .aie(aie_q)
);

// File: tb/test_alarm_match.sv
`timescale 1ns/1ps
module test_alarm_match;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ref_8k = 1'b1;
  logic [7:0] now_hund = 0, now_sec = 0, now_min = 0, now_hour = 0;
  logic [7:0] now_date = 0, now_month = 0, now_wday = 0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic alarm_flag, irq_n;

  int vectors = 0, errors = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  alarm_match i_alarm_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ref_8k(ref_8k),
    .now_hund(now_hund), .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_date(now_date), .now_month(now_month), .now_wday(now_wday),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_flag(alarm_flag), .irq_n(irq_n)
  );

  task automatic check(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && tick) begin
    item_t it;
    #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check(int'(alarm_flag), int'(it.exp), it.tag);
    end
  end

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rchk(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); reg_addr = a; #0.5;
    check(int'(reg_rdata), int'(e), tag);
  endtask

  task automatic set_now(input logic [7:0] h, s, m, hr, d, mo, w);
    now_hund = h; now_sec = s; now_min = m; now_hour = hr;
    now_date = d; now_month = mo; now_wday = w;
  endtask

  task automatic vec(input logic [7:0] h, s, m, hr, d, mo, w, input logic exp, input string tag);
    wreg(4'd8, 8'h00);
    @(negedge clk);
    set_now(h, s, m, hr, d, mo, w);
    sb_q.push_back('{exp, tag});
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input logic en, input logic [1:0] im, input logic [2:0] rpt);
    return {en, 2'b00, im, rpt};
  endfunction

  task automatic pulse_len(input logic [1:0] im, input int exp, input string tag);
    int cnt = 0;
    wreg(4'd7, ctrl(1'b1, im, 3'd7));
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03, 1'b1, tag);
    while (irq_n == 1'b0 && cnt < 5000) begin cnt++; @(negedge clk); end
    check(cnt, exp, tag);
    check(int'(alarm_flag), 1, tag);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(alarm_flag), 0, "R1 reset flag");
    check(int'(irq_n), 1, "R1 reset irq");
    rst_n = 1'b1;
    rchk(4'd7, 8'h00, "R1 reset control");
    rchk(4'd3, 8'h00, "R1 reset alarm hour");

    wreg(4'd0, 8'h37); wreg(4'd1, 8'h12); wreg(4'd2, 8'h45); wreg(4'd3, 8'h31);
    wreg(4'd4, 8'h15); wreg(4'd5, 8'h06); wreg(4'd6, 8'h03);
    wreg(4'd7, 8'hFF);
    rchk(4'd3, 8'h31, "R1 alarm hour readback");
    rchk(4'd6, 8'h03, "R1 weekday readback");
    rchk(4'd7, 8'h9F, "R1 control readback");
    wreg(4'd7, ctrl(1'b0, 2'd0, 3'd0));

    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03, 1'b0, "R3 repeat 0 disabled");

    wreg(4'd7, ctrl(1'b0, 2'd0, 3'd7));
    @(negedge clk); set_now(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03);
    repeat (4) @(negedge clk);
    check(int'(alarm_flag), 0, "R2 no tick no flag");
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03, 1'b1, "R2 tick match sets");
    vec(8'h38, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03, 1'b0, "R4 rpt7 hund differs");
    vec(8'h37, 8'h59, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 1'b1, "R4 rpt7 others ignored");

    wreg(4'd7, ctrl(1'b0, 2'd0, 3'd6));
    vec(8'h37, 8'h59, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03, 1'b0, "R4 rpt6 sec differs");
    vec(8'h37, 8'h12, 8'h00, 8'h31, 8'h15, 8'h06, 8'h03, 1'b1, "R4 rpt6 min ignored");

    wreg(4'd7, ctrl(1'b0, 2'd0, 3'd5));
    vec(8'h37, 8'h12, 8'h00, 8'h31, 8'h15, 8'h06, 8'h03, 1'b0, "R4 rpt5 min differs");
    vec(8'h37, 8'h12, 8'h45, 8'h07, 8'h15, 8'h06, 8'h03, 1'b1, "R4 rpt5 hour ignored");

    wreg(4'd7, ctrl(1'b0, 2'd0, 3'd4));
    vec(8'h37, 8'h12, 8'h45, 8'h11, 8'h15, 8'h06, 8'h03, 1'b0, "R5 PM bit compared");
    vec(8'h37, 8'h12, 8'h45, 8'hF1, 8'h15, 8'h06, 8'h03, 1'b1, "R5 hour bits 7:6 ignored");
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h28, 8'h06, 8'h03, 1'b1, "R4 rpt4 date ignored");

    wreg(4'd7, ctrl(1'b0, 2'd0, 3'd3));
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h04, 1'b0, "R4 rpt3 weekday differs");
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h01, 8'h11, 8'h03, 1'b1, "R4 rpt3 date month ignored");
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'hFB, 1'b1, "R5 weekday bits 7:3 ignored");

    wreg(4'd7, ctrl(1'b0, 2'd0, 3'd2));
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h16, 8'h06, 8'h03, 1'b0, "R4 rpt2 date differs");
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h09, 8'h05, 1'b1, "R4 rpt2 month weekday ignored");

    wreg(4'd7, ctrl(1'b0, 2'd0, 3'd1));
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h07, 8'h03, 1'b0, "R4 rpt1 month differs");
    vec(8'h37, 8'h92, 8'hC5, 8'h31, 8'hD5, 8'hE6, 8'h00, 1'b1, "R5 rpt1 upper bits ignored");

    wreg(4'd3, 8'h23); wreg(4'd7, ctrl(1'b0, 2'd0, 3'd4));
    vec(8'h37, 8'h12, 8'h45, 8'h23, 8'h15, 8'h06, 8'h03, 1'b1, "R5 24h hour match");
    vec(8'h37, 8'h12, 8'h45, 8'h03, 8'h15, 8'h06, 8'h03, 1'b0, "R5 24h hour differs");
    wreg(4'd3, 8'h31);

    wreg(4'd0, 8'hF5); wreg(4'd7, ctrl(1'b0, 2'd0, 3'd7));
    vec(8'h25, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 1'b1, "R6 tenths 25");
    vec(8'h95, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 1'b1, "R6 tenths 95");
    vec(8'h26, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 1'b0, "R6 tenths 26");
    wreg(4'd0, 8'hFF);
    vec(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 1'b1, "R6 hundredths 00");
    vec(8'h99, 8'h33, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 1'b1, "R6 hundredths 99");
    wreg(4'd0, 8'h37);

    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03, 1'b1, "R7 set before clear");
    check(int'(irq_n), 1, "R8 enable off irq high");
    wreg(4'd8, 8'h04);
    check(int'(alarm_flag), 1, "R7 write bit2=1 keeps flag");
    rchk(4'd8, 8'h04, "R1 status bit 2");
    wreg(4'd8, 8'hFB);
    check(int'(alarm_flag), 0, "R7 write bit2=0 clears");
    @(negedge clk);
    set_now(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03);
    sb_q.push_back('{1'b1, "R7 match beats clear"});
    tick = 1'b1; reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h00;
    @(negedge clk); tick = 1'b0; reg_we = 1'b0;

    wreg(4'd7, ctrl(1'b1, 2'd0, 3'd7));
    check(int'(irq_n), 0, "R9 level low with flag");
    wreg(4'd8, 8'h00);
    check(int'(irq_n), 1, "R9 level releases on clear");
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03, 1'b1, "R9 level rematch");
    check(int'(irq_n), 0, "R9 level low after match");

    pulse_len(2'd1, 1, "R10 mode1 width");
    check(int'(irq_n), 1, "R10 irq high after pulse");
    pulse_len(2'd2, 128, "R10 mode2 width");
    pulse_len(2'd3, 2048, "R10 mode3 width");

    wreg(4'd7, ctrl(1'b0, 2'd2, 3'd7));
    vec(8'h37, 8'h12, 8'h45, 8'h31, 8'h15, 8'h06, 8'h03, 1'b1, "R8 pulse disabled");
    check(int'(irq_n), 1, "R8 no pulse when disabled");

    repeat (4) @(negedge clk);
    check(sb_q.size(), 0, "scoreboard drained");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule